// File: doc/BRIEF.md
# Dual-Encoding Serial Clock Divider

This block turns the system clock into the timing for a serial-peripheral clock. It reads an 8-bit prescale field and a one-bit encoding select. From these it works out a divisor. It then marks each half-period boundary of the serial clock with a single-cycle strobe. It also reports which half of the serial clock period is current, so that a neighbouring shift register knows when to launch and when to capture.

Two encodings of the prescale field are supported. The compact encoding gives even divisors from 4 to 30. The wide encoding multiplies a 4-bit linear factor by a power of two. Its exponent is spread over non-adjacent field bits, which gives divisors up to 1920. Software picks the field value. The block only decodes the value and counts.

The divisor is captured while the shifter is idle, and again at a word boundary that the shifter signals. A change of the field in the middle of a word therefore never shortens or stretches a half-period that is already running.

Top module: `sclk_divider`

## Requirements
- R1: With `enc_sel` = 0, the divisor is twice the value in field bits 3:0. A value of 0 or 1 in those bits gives a divisor of 4. Field bits 7:4 do not affect the divisor.
- R2: With `enc_sel` = 1, the divisor is F × 2^E. F is field bits 3:0. E is a 3-bit exponent whose bit 0 is field bit 4 and whose bits 2:1 are field bits 7:6. The largest divisor is 1920.
- R3: With `enc_sel` = 1, field bit 5 does not affect the divisor.
- R4: With `enc_sel` = 1, a linear factor of 0 is used as 1.
- R5: For a divisor D, the low half lasts floor(D/2) cycles and the high half lasts ceil(D/2) cycles. A divisor of 1 is run as a divisor of 2.
- R6: While `run` is high, `sclk_phase` is 0 for the first low-half cycles of a word and 1 for the following high-half cycles, and this pattern repeats. `toggle_stb` is high in the last cycle of every half.
- R7: While `run` is low, `toggle_stb` stays 0, `sclk_phase` goes to 0, and the divisor follows the field. The cycle count of the next word is taken from the latest field value.
- R8: While `run` is high, changing the field or `enc_sel` has no effect on the strobe timing unless a word boundary reload occurs.
- R9: If `word_bound` is high in a cycle where `toggle_stb` ends a high half, the next period uses the divisor decoded from the current field. If `word_bound` is high at the end of a low half, it has no effect.
- R10: While `rst` is high, and in the first cycle after it is released, `toggle_stb` and `sclk_phase` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_sel | input | 1 | Prescale encoding: 0 compact, 1 wide |
| presc_field | input | 8 | Prescale field from configuration |
| run | input | 1 | High while the shifter is moving a word |
| word_bound | input | 1 | Shifter indicates the current period ends a word |
| toggle_stb | output | 1 | High in the last cycle of each serial clock half |
| sclk_phase | output | 1 | 0 in the low half, 1 in the high half |

## Verification
Suppose the half-length counter or the held divisor is wrong. Then the first strobe of a word arrives in the wrong cycle, within at most one period of the intended divisor (at most 1920 cycles). The error then shows on `toggle_stb` and `sclk_phase` in the same cycle. A wrong decode of one encoding bit can only be seen by sweeping that bit. Every value of the field under both encodings is therefore timed over a full period. A bad reload rule shows up only in the period that follows a word boundary, so the mid-word field changes are followed across two periods.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    localparam int PRESC_W = 8;
    localparam int LIN_W   = 4;
    localparam int EXP_W   = 3;
    localparam int DIV_W   = LIN_W + (1 << EXP_W) - 1;
    localparam int HALF_W  = DIV_W - 1;

    typedef enum logic {
        ENC_COMPACT = 1'b0,
        ENC_WIDE    = 1'b1
    } presc_enc_e;

    typedef struct packed {
        logic [HALF_W-1:0] lo_len;
        logic [HALF_W-1:0] hi_len;
    } half_split_t;

    // compact form: even divisors, low nibble is half the divisor
    function automatic logic [DIV_W-1:0] compact_divisor(input logic [PRESC_W-1:0] fld);
        logic [LIN_W-1:0] half;
        half = (fld[LIN_W-1:0] < LIN_W'(2)) ? LIN_W'(2) : fld[LIN_W-1:0];
        return DIV_W'({half, 1'b0});
    endfunction

    // wide form: linear factor shifted by a split exponent
    function automatic logic [DIV_W-1:0] wide_divisor(input logic [PRESC_W-1:0] fld);
        logic [LIN_W-1:0] lin;
        logic [EXP_W-1:0] expo;
        lin  = (fld[LIN_W-1:0] == '0) ? LIN_W'(1) : fld[LIN_W-1:0];
        expo = {fld[7], fld[6], fld[4]};
        return DIV_W'(lin) << expo;
    endfunction

endpackage

// File: rtl/presc_decode.sv
module presc_decode
    import sclk_div_pkg::*;
#(
    parameter int FIELD_W = PRESC_W
) (
    input  presc_enc_e          enc,
    input  logic [FIELD_W-1:0]  field,
    output logic [DIV_W-1:0]    divisor
);
    logic [DIV_W-1:0] cand [2];

    generate
        for (genvar g = 0; g < 2; g++) begin : g_form
            if (g == 0) begin : g_compact
                assign cand[g] = compact_divisor(PRESC_W'(field));
            end else begin : g_wide
                assign cand[g] = wide_divisor(PRESC_W'(field));
            end
        end
    endgenerate

    assign divisor = (enc == ENC_WIDE) ? cand[1] : cand[0];
endmodule

// File: rtl/half_split.sv
module half_split
    import sclk_div_pkg::*;
(
    input  logic [DIV_W-1:0] divisor,
    output half_split_t      halves
);
    logic [DIV_W-1:0] d_eff;
    logic [DIV_W-1:0] lo_full;

    always_comb begin
        d_eff          = (divisor < DIV_W'(2)) ? DIV_W'(2) : divisor;
        lo_full        = d_eff >> 1;
        halves.lo_len  = HALF_W'(lo_full);
        halves.hi_len  = HALF_W'(d_eff - lo_full);
    end
endmodule

// File: rtl/sclk_timer.sv
module sclk_timer
    import sclk_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              word_bound,
    input  logic [DIV_W-1:0]  fresh_div,
    input  half_split_t       fresh_halves,
    output logic              toggle_stb,
    output logic              phase_hi,
    output logic [DIV_W-1:0]  div_held,
    output logic [HALF_W-1:0] cnt_now
);
    logic [DIV_W-1:0]  div_q;
    logic [HALF_W-1:0] cnt_q;
    logic              phase_q;
    half_split_t       held_halves;

    half_split u_held_split (
        .divisor (div_q),
        .halves  (held_halves)
    );

    assign toggle_stb = run && (cnt_q == '0);
    assign phase_hi   = phase_q;
    assign div_held   = div_q;
    assign cnt_now    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= DIV_W'(4);
            cnt_q   <= HALF_W'(1);
            phase_q <= 1'b0;
        end else if (!run) begin
            div_q   <= fresh_div;
            cnt_q   <= fresh_halves.lo_len - HALF_W'(1);
            phase_q <= 1'b0;
        end else if (cnt_q == '0) begin
            if (!phase_q) begin
                phase_q <= 1'b1;
                cnt_q   <= held_halves.hi_len - HALF_W'(1);
            end else begin
                phase_q <= 1'b0;
                if (word_bound) begin
                    div_q <= fresh_div;
                    cnt_q <= fresh_halves.lo_len - HALF_W'(1);
                end else begin
                    cnt_q <= held_halves.lo_len - HALF_W'(1);
                end
            end
        end else begin
            cnt_q <= cnt_q - HALF_W'(1);
        end
    end
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
    import sclk_div_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enc_sel,
    input  logic [PRESC_W-1:0] presc_field,
    input  logic               run,
    input  logic               word_bound,
    output logic               toggle_stb,
    output logic               sclk_phase
);
    presc_enc_e        enc;
    logic [DIV_W-1:0]  fresh_div;
    half_split_t       fresh_halves;
    logic [DIV_W-1:0]  div_held;
    logic [HALF_W-1:0] cnt_now;

    assign enc = presc_enc_e'(enc_sel);

    presc_decode #(.FIELD_W(PRESC_W)) u_decode (
        .enc     (enc),
        .field   (presc_field),
        .divisor (fresh_div)
    );

    half_split u_fresh_split (
        .divisor (fresh_div),
        .halves  (fresh_halves)
    );

    sclk_timer u_timer (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .word_bound   (word_bound),
        .fresh_div    (fresh_div),
        .fresh_halves (fresh_halves),
        .toggle_stb   (toggle_stb),
        .phase_hi     (sclk_phase),
        .div_held     (div_held),
        .cnt_now      (cnt_now)
    );
endmodule

// File: rtl/sclk_divider_chk.sv
module sclk_divider_chk
    import sclk_div_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              word_bound,
    input logic              toggle_stb,
    input logic              sclk_phase,
    input logic [DIV_W-1:0]  div_held,
    input logic [HALF_W-1:0] cnt_now
);
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !toggle_stb);

    // R7
    idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk_phase);

    // R6
    phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (run && toggle_stb) |=> (sclk_phase != $past(sclk_phase)));

    // R6
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !toggle_stb) |=> $stable(sclk_phase));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !(word_bound && toggle_stb && sclk_phase)) |=> $stable(div_held));

    // R2
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        (div_held >= DIV_W'(1)) && (div_held <= DIV_W'(1920)));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_now < HALF_W'(960));
endmodule

bind sclk_divider sclk_divider_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .word_bound (word_bound),
    .toggle_stb (toggle_stb),
    .sclk_phase (sclk_phase),
    .div_held   (div_held),
    .cnt_now    (cnt_now)
);

// File: tb/sclk_divider_tb.sv
module sclk_divider_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       enc_sel;
    logic [7:0] presc_field;
    logic       run;
    logic       word_bound;
    logic       toggle_stb;
    logic       sclk_phase;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sclk_divider dut_i (
        .clk         (clk),
        .rst         (rst),
        .enc_sel     (enc_sel),
        .presc_field (presc_field),
        .run         (run),
        .word_bound  (word_bound),
        .toggle_stb  (toggle_stb),
        .sclk_phase  (sclk_phase)
    );

    function automatic int exp_div(input logic ext, input int f);
        int n, e;
        n = f % 16;
        if (!ext) return (n < 2) ? 4 : 2 * n;
        if (n == 0) n = 1;
        e = ((f / 64) % 4) * 2 + ((f / 16) % 2);
        return n * (1 << e);
    endfunction

    task automatic report(input string req, input int ok, input int act_s, input int act_p,
                          input int exp_s, input int exp_p, input int cyc);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: strobe/phase actual %0d/%0d expected %0d/%0d",
                     req, cyc, act_s, act_p, exp_s, exp_p);
        end
    endtask

    // time one word of a constant divisor, cycles 1..ncyc of run
    task automatic time_word(input string req, input logic ext, input int f, input int ncyc);
        int d, lo, hi, bad, bs, bp, es, ep, bk;
        d  = exp_div(ext, f);
        if (d < 2) d = 2;
        lo = d / 2;
        hi = d - lo;
        bad = 0; bs = 0; bp = 0; es = 0; ep = 0; bk = 0;
        @(negedge clk);
        run = 1'b0; enc_sel = ext; presc_field = 8'(f); word_bound = 1'b0;
        @(negedge clk);
        run = 1'b1;
        for (int k = 1; k <= ncyc; k++) begin
            int xs, xp;
            #2;
            xs = (k >= lo && (((k - lo) % d) == 0 || (k % d) == 0)) ? 1 : 0;
            xp = (((k - 1) % d) >= lo) ? 1 : 0;
            if (!bad && (int'(toggle_stb) != xs || int'(sclk_phase) != xp)) begin
                bad = 1; bs = toggle_stb; bp = sclk_phase; es = xs; ep = xp; bk = k;
            end
            @(negedge clk);
        end
        run = 1'b0;
        report(req, !bad, bs, bp, es, ep, bk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; run = 1'b1; enc_sel = 1'b0; presc_field = 8'h13; word_bound = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        report("R10", (toggle_stb == 1'b0 && sclk_phase == 1'b0), toggle_stb, sclk_phase, 0, 0, 0);
        run = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        report("R10", (toggle_stb == 1'b0 && sclk_phase == 1'b0), toggle_stb, sclk_phase, 0, 0, 1);

        // R7 idle: no strobes, phase low, across field changes
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                enc_sel = k[0]; presc_field = 8'(k * 13);
                #2;
                if (toggle_stb || sclk_phase) bad = 1;
            end
            report("R7", !bad, toggle_stb, sclk_phase, 0, 0, 20);
        end

        // R1 compact encoding, all field values, two full periods
        for (int f = 0; f < 256; f++) time_word("R1", 1'b0, f, 2 * exp_div(1'b0, f) + 1);

        // R2 R3 R4 R5 R6 wide encoding, all field values, one period plus one cycle
        for (int f = 0; f < 256; f++) begin
            string tag;
            int dv;
            dv = exp_div(1'b1, f);
            if ((f % 16) == 0)      tag = "R4";
            else if (dv % 2 == 1)   tag = "R5";
            else if ((f / 32) % 2)  tag = "R3";
            else                    tag = "R2";
            time_word(tag, 1'b1, f, (dv < 2 ? 2 : dv) + 1);
        end

        // R6 largest divisor over two periods
        time_word("R6", 1'b1, 8'hDF, 3841);

        // R8 mid-word field change without word boundary
        begin
            int bad, bs, bp, es, ep, bk;
            bad = 0; bs = 0; bp = 0; es = 0; ep = 0; bk = 0;
            @(negedge clk);
            run = 1'b0; enc_sel = 1'b0; presc_field = 8'h13; word_bound = 1'b0;
            @(negedge clk);
            run = 1'b1;
            for (int k = 1; k <= 13; k++) begin
                int xs, xp;
                if (k == 2) begin presc_field = 8'h1F; enc_sel = 1'b1; end
                #2;
                xs = (k % 3 == 0) ? 1 : 0;
                xp = (((k - 1) % 6) >= 3) ? 1 : 0;
                if (!bad && (int'(toggle_stb) != xs || int'(sclk_phase) != xp)) begin
                    bad = 1; bs = toggle_stb; bp = sclk_phase; es = xs; ep = xp; bk = k;
                end
                @(negedge clk);
            end
            run = 1'b0;
            report("R8", !bad, bs, bp, es, ep, bk);
        end

        // R9 word boundary reload: divisor 6 then 8
        begin
            int bad, bs, bp, es, ep, bk;
            bad = 0; bs = 0; bp = 0; es = 0; ep = 0; bk = 0;
            @(negedge clk);
            run = 1'b0; enc_sel = 1'b0; presc_field = 8'h13; word_bound = 1'b1;
            @(negedge clk);
            run = 1'b1;
            for (int k = 1; k <= 14; k++) begin
                int xs, xp;
                if (k == 2) presc_field = 8'h14;
                #2;
                xs = (k == 3 || k == 6 || k == 10 || k == 14) ? 1 : 0;
                xp = ((k >= 4 && k <= 6) || (k >= 11)) ? 1 : 0;
                if (!bad && (int'(toggle_stb) != xs || int'(sclk_phase) != xp)) begin
                    bad = 1; bs = toggle_stb; bp = sclk_phase; es = xs; ep = xp; bk = k;
                end
                @(negedge clk);
            end
            run = 1'b0; word_bound = 1'b0;
            report("R9", !bad, bs, bp, es, ep, bk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule